// File: doc/BRIEF.md
# Program/Erase Status Reporter

This block decides what a read of the memory returns while an embedded program or erase is running and just after it ends. When no operation is active, array data passes straight through. While an operation runs, and in the held states that follow it, a status word replaces the array data.

In the status word, bit 7 is a polling bit and bit 6 toggles on each read while busy. Bit 5 reports a failed operation, and all other bits read 0. A two-value configuration register decides what happens after a successful operation: the block either returns to array read by itself, or keeps showing status until an exit command arrives. A failed operation always waits for that exit command. A ready/busy output follows the operation.

The block has two resets. The power-on reset (`por_n`) clears everything, including the configuration register. The device reset pin (`rst_n`) returns the block to array read and leaves the configuration register unchanged.

States of the controller:
- `ST_ARRAY`: array read.
- `ST_BUSY_PGM`: program running.
- `ST_BUSY_ERS`: erase running.
- `ST_HOLD_PASS`: success held, waiting for the exit command.
- `ST_HOLD_FAIL`: failure held, waiting for the exit command.

Transitions:
- start: `op_busy` sampled high in `ST_ARRAY`, `ST_HOLD_PASS` or `ST_HOLD_FAIL` moves to `ST_BUSY_ERS` when `op_is_erase`=1, otherwise to `ST_BUSY_PGM`.
- finish-fail: in a busy state, `op_busy` low with `op_fail`=1 moves to `ST_HOLD_FAIL`.
- finish-hold: in a busy state, `op_busy` low with `op_fail`=0 and configuration 01 moves to `ST_HOLD_PASS`.
- finish-auto: in a busy state, `op_busy` low with `op_fail`=0 and configuration 00 moves to `ST_ARRAY`.
- exit: `id_exit` in either hold state moves to `ST_ARRAY`.
- reset: either reset moves to `ST_ARRAY`.

Top module: `pgm_erase_status`

## Requirements
- R1: In array-read state, `rd_data` equals `arr_data` and `rdy` is 1; after power-on reset the block is in array-read state.
- R2: `rdy` goes to 0 on the clock after `op_busy` is sampled 1 while ready. It returns to 1 on the clock after `op_busy` is sampled 0.
- R3: While a program runs, `rd_data` bit 7 is the inverse of `prog_poll_bit`, bit 5 is 0, and every bit other than 7, 6 and 5 is 0.
- R4: While an erase runs, `rd_data` bit 7 is 0.
- R5: `rd_data` bit 6 inverts after each clock with `rd_en`=1 in a busy state. It does not change on reads in a held state.
- R6: A successful operation (`op_fail`=0 when `op_busy` is sampled 0) with configuration 00 shows array data on the next clock.
- R7: A successful operation with configuration 01 keeps the status word until `id_exit`. In that word, bit 5 is 0 and bit 7 carries the true data: `prog_poll_bit` after a program, 1 after an erase.
- R8: A failed operation keeps the status word with bit 5 = 1 until `id_exit`, whatever the configuration. In that word, bit 7 is the inverse of `prog_poll_bit` after a program and 0 after an erase.
- R9: A pulse on `cfg_wr` stores `cfg_val` only when the value is 00 or 01 and no operation is running. Any other value, or any write during an operation, leaves the configuration unchanged.
- R10: `rst_n` low forces array-read state and ends an operation, but keeps the configuration value. `por_n` low also clears the configuration to 00.
- R11: `id_exit` in array-read state has no effect on `rd_data` or `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Device reset pin, active low, keeps configuration |
| op_busy | input | 1 | Embedded operation running |
| op_is_erase | input | 1 | 1 = erase, 0 = program, sampled at start |
| op_fail | input | 1 | Operation result, sampled when `op_busy` is seen low |
| prog_poll_bit | input | 1 | Bit 7 of the last programmed data |
| cfg_wr | input | 1 | Set-configuration strobe from the command decoder |
| cfg_val | input | 2 | Configuration value written by `cfg_wr` |
| id_exit | input | 1 | Exit strobe from the command decoder |
| rd_en | input | 1 | A read is taking place this cycle |
| arr_data | input | DATA_W | Data read from the array |
| rd_data | output | DATA_W | Data returned to the reader |
| rdy | output | 1 | Ready/busy: 0 while an operation runs |

## Verification
The assertions check on every cycle that ready drops after a start. They also check the polling bit during a program or an erase, the toggle inversion on busy reads, and that a held failure stays put and reports its fail bit. They further check that the configuration changes only on a write, whatever `rst_n` does. Only the bench's scenarios show the sequences: automatic return against a held success, ignored configuration values and writes during a busy period, an exit command with nothing to exit, and the difference between the two resets across a later operation.

// File: rtl/pes_pkg.sv
package pes_pkg;
    typedef enum logic [2:0] {
        ST_ARRAY     = 3'd0,
        ST_BUSY_PGM  = 3'd1,
        ST_BUSY_ERS  = 3'd2,
        ST_HOLD_PASS = 3'd3,
        ST_HOLD_FAIL = 3'd4
    } pes_state_e;

    localparam int CFG_W = 2;
endpackage

// File: rtl/pes_cfg_reg.sv
module pes_cfg_reg
    import pes_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] val,
    input  logic             allow,
    output logic             hold_after_pass
);
    logic legal;

    always_comb begin
        legal = (val[CFG_W-1:1] == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_after_pass <= 1'b0;
        end else if (wr && allow && legal) begin
            hold_after_pass <= val[0];
        end
    end
endmodule

// File: rtl/pes_fsm.sv
module pes_fsm
    import pes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_busy,
    input  logic       op_is_erase,
    input  logic       op_fail,
    input  logic       id_exit,
    input  logic       hold_after_pass,
    output pes_state_e state_q,
    output logic       was_erase,
    output logic       busy,
    output logic       show_status
);
    pes_state_e state_d;
    logic       start;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_ARRAY: begin
                if (op_busy) begin
                    start   = 1'b1;
                    state_d = op_is_erase ? ST_BUSY_ERS : ST_BUSY_PGM;
                end
            end
            ST_BUSY_PGM, ST_BUSY_ERS: begin
                if (!op_busy) begin
                    if (op_fail)              state_d = ST_HOLD_FAIL;
                    else if (hold_after_pass) state_d = ST_HOLD_PASS;
                    else                      state_d = ST_ARRAY;
                end
            end
            ST_HOLD_PASS, ST_HOLD_FAIL: begin
                if (op_busy) begin
                    start   = 1'b1;
                    state_d = op_is_erase ? ST_BUSY_ERS : ST_BUSY_PGM;
                end else if (id_exit) begin
                    state_d = ST_ARRAY;
                end
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ARRAY;
            was_erase <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) was_erase <= op_is_erase;
        end
    end

    always_comb begin
        busy        = 1'b0;
        show_status = 1'b1;
        unique case (state_q)
            ST_ARRAY:                 show_status = 1'b0;
            ST_BUSY_PGM, ST_BUSY_ERS: busy        = 1'b1;
            ST_HOLD_PASS, ST_HOLD_FAIL: ;
            default:                  show_status = 1'b0;
        endcase
    end
endmodule

// File: rtl/pes_toggle.sv
module pes_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_en,
    output logic tog_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            tog_q <= 1'b0;
        else if (busy && rd_en) tog_q <= ~tog_q;
    end
endmodule

// File: rtl/pes_word.sv
module pes_word
    import pes_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  pes_state_e        state_q,
    input  logic              was_erase,
    input  logic              show_status,
    input  logic              tog_q,
    input  logic              prog_poll_bit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              poll_v;
    logic              fail_v;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        poll_v = 1'b0;
        fail_v = 1'b0;
        unique case (state_q)
            ST_BUSY_PGM:  poll_v = ~prog_poll_bit;
            ST_BUSY_ERS:  poll_v = 1'b0;
            ST_HOLD_PASS: poll_v = was_erase ? 1'b1 : prog_poll_bit;
            ST_HOLD_FAIL: begin
                poll_v = was_erase ? 1'b0 : ~prog_poll_bit;
                fail_v = 1'b1;
            end
            ST_ARRAY: ;
            default: ;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign stat_word[i] = poll_v;
        end else if (i == TOG_BIT) begin : g_tog
            assign stat_word[i] = tog_q;
        end else if (i == FAIL_BIT) begin : g_fail
            assign stat_word[i] = fail_v;
        end else begin : g_zero
            assign stat_word[i] = 1'b0;
        end
    end

    assign rd_data = show_status ? stat_word : arr_data;
endmodule

// File: rtl/pgm_erase_status.sv
module pgm_erase_status
    import pes_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              op_busy,
    input  logic              op_is_erase,
    input  logic              op_fail,
    input  logic              prog_poll_bit,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_val,
    input  logic              id_exit,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy
);
    logic       sys_rst_n;
    logic       hold_after_pass;
    pes_state_e fsm_state;
    logic       was_erase;
    logic       busy;
    logic       show_status;
    logic       tog_q;

    assign sys_rst_n = por_n & rst_n;

    pes_cfg_reg u_cfg (
        .clk             (clk),
        .por_n           (por_n),
        .wr              (cfg_wr),
        .val             (cfg_val),
        .allow           (~busy),
        .hold_after_pass (hold_after_pass)
    );

    pes_fsm u_fsm (
        .clk             (clk),
        .rst_n           (sys_rst_n),
        .op_busy         (op_busy),
        .op_is_erase     (op_is_erase),
        .op_fail         (op_fail),
        .id_exit         (id_exit),
        .hold_after_pass (hold_after_pass),
        .state_q         (fsm_state),
        .was_erase       (was_erase),
        .busy            (busy),
        .show_status     (show_status)
    );

    pes_toggle u_tog (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .busy  (busy),
        .rd_en (rd_en),
        .tog_q (tog_q)
    );

    pes_word #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT),
        .FAIL_BIT (FAIL_BIT)
    ) u_word (
        .state_q       (fsm_state),
        .was_erase     (was_erase),
        .show_status   (show_status),
        .tog_q         (tog_q),
        .prog_poll_bit (prog_poll_bit),
        .arr_data      (arr_data),
        .rd_data       (rd_data)
    );

    assign rdy = ~busy;
endmodule

// File: rtl/pgm_erase_status_chk.sv
module pgm_erase_status_chk
    import pes_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              op_busy,
    input logic              prog_poll_bit,
    input logic              cfg_wr,
    input logic              id_exit,
    input logic              rd_en,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy,
    input pes_state_e        state,
    input logic              cfg_hold
);
    logic in_busy;
    assign in_busy = (state == ST_BUSY_PGM) || (state == ST_BUSY_ERS);

    // R1
    a_r1_array_passthru: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state == ST_ARRAY) |-> (rd_data == arr_data && rdy));

    // R2
    a_r2_rdy_drops: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rdy && op_busy) |=> !rdy);

    // R3
    a_r3_pgm_poll: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state == ST_BUSY_PGM) |-> (rd_data[POLL_BIT] == ~prog_poll_bit));

    // R4
    a_r4_ers_poll_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state == ST_BUSY_ERS) |-> !rd_data[POLL_BIT]);

    // R5
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (in_busy && rd_en && op_busy) |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

    // R8
    a_r8_fail_persists: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state == ST_HOLD_FAIL && !id_exit && !op_busy) |=> (state == ST_HOLD_FAIL));

    // R8
    a_r8_fail_flag: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state == ST_HOLD_FAIL) |-> rd_data[FAIL_BIT]);

    // R10
    a_r10_cfg_only_on_write: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_wr |=> $stable(cfg_hold));
endmodule

bind pgm_erase_status pgm_erase_status_chk #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT),
    .FAIL_BIT (FAIL_BIT)
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .rst_n         (rst_n),
    .op_busy       (op_busy),
    .prog_poll_bit (prog_poll_bit),
    .cfg_wr        (cfg_wr),
    .id_exit       (id_exit),
    .rd_en         (rd_en),
    .arr_data      (arr_data),
    .rd_data       (rd_data),
    .rdy           (rdy),
    .state         (fsm_state),
    .cfg_hold      (hold_after_pass)
);

// File: tb/pgm_erase_status_tb.sv
`timescale 1ns/100ps
module pgm_erase_status_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_busy = 1'b0;
    logic          op_is_erase = 1'b0;
    logic          op_fail = 1'b0;
    logic          prog_poll_bit = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_val = 2'b00;
    logic          id_exit = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] arr_data = 16'h00FF;
    logic [DW-1:0] rd_data;
    logic          rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pgm_erase_status u_dut (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .op_busy       (op_busy),
        .op_is_erase   (op_is_erase),
        .op_fail       (op_fail),
        .prog_poll_bit (prog_poll_bit),
        .cfg_wr        (cfg_wr),
        .cfg_val       (cfg_val),
        .id_exit       (id_exit),
        .rd_en         (rd_en),
        .arr_data      (arr_data),
        .rd_data       (rd_data),
        .rdy           (rdy)
    );

    // Behavioural reference: 0 array, 1 program, 2 erase, 3 held pass, 4 held fail
    int m_st   = 0;
    bit m_ers  = 0;
    bit m_tog  = 0;
    bit m_cfg  = 0;

    always @(posedge clk) begin
        int  n_st;
        bit  n_ers, n_tog, n_cfg, bsy;
        if (!por_n) begin
            m_st = 0; m_ers = 0; m_tog = 0; m_cfg = 0;
        end else if (!rst_n) begin
            m_st = 0; m_ers = 0; m_tog = 0;
        end else begin
            bsy   = (m_st == 1) || (m_st == 2);
            n_st  = m_st; n_ers = m_ers; n_tog = m_tog; n_cfg = m_cfg;
            if (bsy && rd_en) n_tog = !m_tog;
            if (!bsy && cfg_wr && !cfg_val[1]) n_cfg = cfg_val[0];
            if (bsy) begin
                if (!op_busy) n_st = op_fail ? 4 : (m_cfg ? 3 : 0);
            end else if (op_busy) begin
                n_st  = op_is_erase ? 2 : 1;
                n_ers = op_is_erase;
            end else if (m_st != 0 && id_exit) begin
                n_st = 0;
            end
            m_st = n_st; m_ers = n_ers; m_tog = n_tog; m_cfg = n_cfg;
        end
    end

    function automatic logic [DW-1:0] model_word();
        logic [DW-1:0] w;
        if (m_st == 0) return arr_data;
        w    = '0;
        w[6] = m_tog;
        w[5] = (m_st == 4);
        case (m_st)
            1:       w[7] = !prog_poll_bit;
            2:       w[7] = 1'b0;
            3:       w[7] = m_ers ? 1'b1 : prog_poll_bit;
            default: w[7] = m_ers ? 1'b0 : !prog_poll_bit;
        endcase
        return w;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            logic [DW-1:0] ew;
            bit            er;
            string         tag;
            ew = model_word();
            er = !((m_st == 1) || (m_st == 2));
            case (m_st)
                0: tag = "R1"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R7"; default: tag = "R8";
            endcase
            checks++;
            if (rd_data !== ew) begin
                fails++;
                $display("FAIL %s model rd_data got %h exp %h", tag, rd_data, ew);
            end
            checks++;
            if (rdy !== er) begin
                fails++;
                $display("FAIL R2 model rdy got %b exp %b", rdy, er);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); #0.5; endtask
    task automatic look(); #0.5; endtask

    task automatic run_op(input bit ers, input bit fail);
        op_is_erase = ers; op_busy = 1'b1;
        cyc();
        op_busy = 1'b0; op_fail = fail;
        cyc();
        op_fail = 1'b0;
    endtask

    task automatic exit_cmd();
        id_exit = 1'b1; cyc(); id_exit = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] v);
        cfg_val = v; cfg_wr = 1'b1; cyc(); cfg_wr = 1'b0;
    endtask

    initial begin
        bit t0;
        repeat (3) cyc();
        por_n = 1'b1; rst_n = 1'b1;
        cyc(); look();
        chk("R1 reset rdy", rdy, 1);
        chk("R1 reset passthru", rd_data, 16'h00FF);

        exit_cmd(); look();
        chk("R11 exit in array data", rd_data, 16'h00FF);
        chk("R11 exit in array rdy", rdy, 1);

        // program with configuration 00
        prog_poll_bit = 1'b1; op_is_erase = 1'b0; op_busy = 1'b1;
        cyc(); look();
        chk("R2 rdy low", rdy, 0);
        chk("R3 poll inverted", rd_data[7], 0);
        chk("R3 other bits zero", rd_data & 16'hFF1F, 0);
        rd_en = 1'b1; t0 = rd_data[6];
        cyc(); look();
        chk("R5 toggle 1", rd_data[6], !t0);
        cyc(); look();
        chk("R5 toggle 2", rd_data[6], t0);
        rd_en = 1'b0;
        cyc(); look();
        chk("R5 no read no toggle", rd_data[6], t0);
        op_busy = 1'b0;
        cyc(); look();
        chk("R2 rdy back", rdy, 1);
        chk("R6 auto return", rd_data, 16'h00FF);

        // erase with configuration 00
        arr_data = 16'h0080; op_is_erase = 1'b1; op_busy = 1'b1;
        cyc(); look();
        chk("R4 erase poll zero", rd_data[7], 0);
        op_busy = 1'b0;
        cyc(); look();
        chk("R6 erase auto return", rd_data, 16'h0080);

        // configuration 01: held pass
        set_cfg(2'b01);
        prog_poll_bit = 1'b0;
        run_op(1'b0, 1'b0); look();
        chk("R7 held rdy", rdy, 1);
        chk("R7 held poll true", rd_data[7], 0);
        chk("R7 held no fail", rd_data[5], 0);
        rd_en = 1'b1; t0 = rd_data[6];
        cyc(); look();
        chk("R5 frozen when held", rd_data[6], t0);
        rd_en = 1'b0;
        repeat (3) cyc();
        look();
        chk("R7 still held", rd_data[7], 0);
        set_cfg(2'b10);
        exit_cmd(); look();
        chk("R7 exit returns", rd_data, 16'h0080);

        // illegal value and write during busy ignored
        op_is_erase = 1'b0; op_busy = 1'b1;
        cyc();
        cfg_val = 2'b00; cfg_wr = 1'b1;
        cyc();
        cfg_wr = 1'b0; op_busy = 1'b0;
        cyc(); look();
        chk("R9 cfg kept 01", rd_data, 16'h0000);
        exit_cmd(); look();
        chk("R9 exit", rd_data, 16'h0080);

        arr_data = 16'h0000;
        run_op(1'b1, 1'b0); look();
        chk("R7 erase held poll one", rd_data[7], 1);
        exit_cmd();

        // failure with configuration 00
        set_cfg(2'b00);
        run_op(1'b1, 1'b1); look();
        chk("R8 fail flag", rd_data[5], 1);
        chk("R8 erase fail poll", rd_data[7], 0);
        repeat (4) cyc();
        look();
        chk("R8 fail persists", rd_data[5], 1);
        exit_cmd(); look();
        chk("R8 exit", rd_data, 16'h0000);
        prog_poll_bit = 1'b1;
        run_op(1'b0, 1'b1); look();
        chk("R8 program fail poll", rd_data[7], 0);
        exit_cmd();

        // device reset keeps configuration
        arr_data = 16'h00FF; prog_poll_bit = 1'b0;
        set_cfg(2'b01);
        rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
        run_op(1'b0, 1'b0); look();
        chk("R10 cfg survives rst_n", rd_data[7], 0);
        exit_cmd();
        op_is_erase = 1'b0; op_busy = 1'b1;
        cyc(); look();
        chk("R2 busy before reset", rdy, 0);
        rst_n = 1'b0; op_busy = 1'b0; look();
        chk("R10 reset ends op", rdy, 1);
        chk("R10 reset array", rd_data, 16'h00FF);
        cyc(); rst_n = 1'b1; cyc();

        // power-on reset clears configuration
        por_n = 1'b0; cyc(); por_n = 1'b1; cyc();
        run_op(1'b0, 1'b0); look();
        chk("R10 por clears cfg", rd_data, 16'h00FF);

        cyc();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule